// File: doc/BRIEF.md
# Glitch-Free Card Clock Generator

This block generates the clock that drives a smart card contact. It takes two unrelated clocks: a crystal clock and an internal oscillator clock. A 3-bit select field picks one of these outputs:

- the crystal clock, undivided;
- the crystal clock divided by 2, 4 or 8;
- half the oscillator clock.

Any change of setting goes through a break-before-make enable handshake. Every candidate clock has its own enable flop, clocked on the edge that ends that clock's active phase. So a source is only removed or added while the output sits at its rest level, and no phase is ever cut short.

Two further controls act on the output. A stop input parks the output at a fixed level for asynchronous cards. A synchronous-card mode hands the output to a bit written by software. A busy flag stays high while the enabled source differs from the requested one. Software reads it before sending further commands to the card.

Top module: `card_clk_gen`

## Requirements
- R1: With select 000 and stop and sync mode low, clk_o follows the crystal clock, with the crystal's own period and duty cycle.
- R2: With select 001, 010 or 011, clk_o runs at the crystal period times 2, 4 or 8 respectively, with equal high and low phases.
- R3: With select bit 2 set (100 to 111), clk_o runs at twice the oscillator period, with equal high and low phases; the two low bits are ignored.
- R4: At most one source is gated onto clk_o at any time. Across any change of select or stop, no high or low phase of clk_o is shorter than the shorter half-period of the old and the new setting.
- R5: busy_o rises as soon as a request names a different source from the enabled one, stays low when the new select value names the same source, and falls once the new setting drives clk_o.
- R6: With stop high and sync mode low, clk_o settles at the parked level (PARK_HIGH, default low) and stays there. Releasing stop restores the selected rate.
- R7: With sync mode high, clk_o equals sync_bit_i and ignores select and stop; no source clock reaches the output.
- R8: While rst_ni is low, clk_o is at the parked level. Within 12 crystal cycles after reset with select 000, busy_o is low and clk_o runs at the crystal clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| xtal_clk_i | input | 1 | Crystal clock |
| osc_clk_i | input | 1 | Internal oscillator clock, unrelated to the crystal |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 3 | Rate select: 000 crystal, 001/010/011 crystal /2 /4 /8, 1xx oscillator /2 |
| stop_i | input | 1 | Park the card clock (asynchronous cards) |
| sync_mode_i | input | 1 | Synchronous-card mode: output follows sync_bit_i |
| sync_bit_i | input | 1 | Software-written clock level for synchronous cards |
| clk_o | output | 1 | Card clock |
| busy_o | output | 1 | Requested setting not yet in effect |

## Verification
The checks assume that software holds select and stop steady until busy_o has fallen. This matters for the single-source and enable-ordering checks: a second request made while the synchronizers still carry the first one could let two domains see stale state at once. The stimulus keeps to this rule. Every change of select or stop is followed by a wait for busy_o to drop before anything else moves. The select field is changed freely only in synchronous-card mode, where no source is requested. The two clocks run at 8 ns and 13 ns, so edges drift against each other across the switches.

// File: rtl/card_clk_pkg.sv
package card_clk_pkg;
  localparam int XDIV_BITS = 3;              // crystal ratios 2^0 .. 2^XDIV_BITS
  localparam int NSRC      = XDIV_BITS + 2;  // crystal ratios + oscillator half
  localparam int SEL_W     = 3;
  localparam int OSC_IDX   = NSRC - 1;
  localparam int SYNC_LEN  = 2;

  function automatic logic [NSRC-1:0] sel_decode(input logic [SEL_W-1:0] sel);
    logic [NSRC-1:0] v;
    v = '0;
    if (sel[SEL_W-1]) v[OSC_IDX] = 1'b1;
    else              v[int'(sel[SEL_W-2:0])] = 1'b1;
    return v;
  endfunction
endpackage

// File: rtl/ccg_div.sv
module ccg_div
  import card_clk_pkg::*;
(
  input  logic            xtal_i,
  input  logic            osc_i,
  input  logic            rst_ni,
  output logic [NSRC-1:0] src_o
);
  logic [XDIV_BITS-1:0] cnt_q;
  logic                 osc_half_q;

  // ripple-free binary count: bit k is xtal / 2^(k+1), 50% duty
  always_ff @(posedge xtal_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge osc_i or negedge rst_ni) begin
    if (!rst_ni) osc_half_q <= 1'b0;
    else         osc_half_q <= ~osc_half_q;
  end

  assign src_o = {osc_half_q, cnt_q, xtal_i};
endmodule

// File: rtl/ccg_gate.sv
module ccg_gate
  import card_clk_pkg::*;
(
  input  logic src_i,     // already polarity-adjusted: falling edge ends active phase
  input  logic rst_ni,
  input  logic want_i,
  input  logic others_i,
  output logic en_o
);
  logic [SYNC_LEN-1:0] want_s, oth_s;

  always_ff @(negedge src_i or negedge rst_ni) begin
    if (!rst_ni) begin
      want_s <= '0;
      oth_s  <= '0;
      en_o   <= 1'b0;
    end else begin
      want_s <= {want_s[SYNC_LEN-2:0], want_i};
      oth_s  <= {oth_s[SYNC_LEN-2:0], others_i};
      en_o   <= want_s[SYNC_LEN-1] & ~oth_s[SYNC_LEN-1];
    end
  end

  // R5
  en_rise_needs_req_chk: assert property (@(negedge src_i) disable iff (!rst_ni)
    $rose(en_o) |-> $past(want_i, 2) && !$past(others_i, 2));
  // R4
  en_fall_needs_cause_chk: assert property (@(negedge src_i) disable iff (!rst_ni)
    $fell(en_o) |-> !$past(want_i, 2) || $past(others_i, 2));
endmodule

// File: rtl/card_clk_gen.sv
module card_clk_gen
  import card_clk_pkg::*;
#(
  parameter bit PARK_HIGH = 1'b0
) (
  input  logic             xtal_clk_i,
  input  logic             osc_clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             stop_i,
  input  logic             sync_mode_i,
  input  logic             sync_bit_i,
  output logic             clk_o,
  output logic             busy_o
);
  logic [NSRC-1:0] src, src_n, en, others, want;
  logic            gated, run_clk;

  ccg_div u_div (
    .xtal_i (xtal_clk_i),
    .osc_i  (osc_clk_i),
    .rst_ni (rst_ni),
    .src_o  (src)
  );

  assign want = (sync_mode_i || stop_i) ? '0 : sel_decode(sel_i);

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    // invert for high park so enables still switch at the end of the active phase
    if (PARK_HIGH) begin : g_inv
      assign src_n[g] = ~src[g];
    end else begin : g_pass
      assign src_n[g] = src[g];
    end
    assign others[g] = |(en & ~(NSRC'(1) << g));

    ccg_gate u_gate (
      .src_i    (src_n[g]),
      .rst_ni   (rst_ni),
      .want_i   (want[g]),
      .others_i (others[g]),
      .en_o     (en[g])
    );
  end

  assign gated   = |(src_n & en);
  assign run_clk = PARK_HIGH ? ~gated : gated;
  assign clk_o   = sync_mode_i ? sync_bit_i : run_clk;
  assign busy_o  = (en != want);

  // R4
  one_source_chk: assert property (@(posedge xtal_clk_i) disable iff (!rst_ni)
    $onehot0(en));
  // R6
  park_level_chk: assert property (@(posedge xtal_clk_i) disable iff (!rst_ni)
    (stop_i && !sync_mode_i && !busy_o) |-> (clk_o == PARK_HIGH));
  // R7
  sync_hold_chk: assert property (@(posedge xtal_clk_i) disable iff (!rst_ni)
    (sync_mode_i && $past(sync_mode_i) && $stable(sync_bit_i)) |-> $stable(clk_o));
endmodule

// File: tb/card_clk_gen_bench.sv
`timescale 1ns/1ps
module card_clk_gen_bench;
  localparam real XP = 8.0;
  localparam real OP = 13.0;
  localparam int  NV = 10;
  // {select, expected period in ns}
  localparam int VEC [NV][2] = '{'{3, 64}, '{4, 26}, '{1, 16}, '{4, 26}, '{5, 26},
                                 '{0, 8},  '{7, 26}, '{2, 32}, '{6, 26}, '{0, 8}};

  logic       xtal = 1'b0, osc = 1'b0, rst_ni = 1'b0;
  logic [2:0] sel = 3'd0;
  logic       stop = 1'b0, smode = 1'b0, sbit = 1'b0;
  logic       clk_o, busy;

  always #(XP/2) xtal = ~xtal;
  always #(OP/2) osc  = ~osc;

  card_clk_gen u_card_clk_gen (
    .xtal_clk_i (xtal), .osc_clk_i (osc), .rst_ni (rst_ni), .sel_i (sel),
    .stop_i (stop), .sync_mode_i (smode), .sync_bit_i (sbit),
    .clk_o (clk_o), .busy_o (busy)
  );

  int  checks = 0, errors = 0, glitches = 0, edges = 0;
  bit  mon_en = 1'b0;
  real min_ok = 4.0, last_edge = -1.0;

  // R4 phase monitor
  always @(clk_o) begin
    edges++;
    if (mon_en && last_edge >= 0.0 && ($realtime - last_edge) < min_ok - 0.01) begin
      glitches++;
      $display("FAIL R4 phase %0.3f ns, expected >= %0.3f", $realtime - last_edge, min_ok);
    end
    last_edge = $realtime;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input real act, input real exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0.3f expected %0.3f", req, what, act, exp);
    end
  endtask

  function automatic real half_of(input int s);
    return (s >= 4) ? OP : XP * real'(1 << (s % 4)) / 2.0;
  endfunction

  function automatic bit same_src(input int a, input int b);
    return (a == b) || (a >= 4 && b >= 4);
  endfunction

  task automatic wait_idle(input string req);
    int n = 0;
    while (busy && n < 2000) begin @(negedge xtal); n++; end
    check(!busy, req, "busy cleared", real'(busy), 0.0);
  endtask

  task automatic measure(output real per, output real hi);
    real t1, t2, t3;
    @(posedge clk_o); t1 = $realtime;
    @(negedge clk_o); t2 = $realtime;
    @(posedge clk_o); t3 = $realtime;
    per = t3 - t1;
    hi  = t2 - t1;
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    real per, hi, hf;
    int  cur, e0, g0;
    string rq;
    repeat (3) @(negedge xtal);
    check(clk_o == 1'b0, "R8", "parked in reset", real'(clk_o), 0.0);
    rst_ni = 1'b1;
    repeat (12) @(negedge xtal);
    check(busy == 1'b0, "R8", "busy after reset", real'(busy), 0.0);
    measure(per, hi);
    check(per > XP - 0.01 && per < XP + 0.01, "R8", "period after reset", per, XP);
    check(hi > XP/2 - 0.01 && hi < XP/2 + 0.01, "R1", "xtal high phase", hi, XP/2);
    cur = 0; mon_en = 1'b1;

    for (int k = 0; k < NV; k++) begin
      int nsel = VEC[k][0];
      real ep = real'(VEC[k][1]);
      rq = (nsel >= 4) ? "R3" : ((nsel == 0) ? "R1" : "R2");
      min_ok = (half_of(cur) < ep/2.0) ? half_of(cur) : ep/2.0;
      g0 = glitches;
      @(negedge xtal); sel = 3'(nsel); #1;
      check(busy == !same_src(cur, nsel), "R5", "busy on request", real'(busy),
            real'(!same_src(cur, nsel)));
      wait_idle("R5");
      measure(per, hi);
      check(per > ep - 0.01 && per < ep + 0.01, rq, "period", per, ep);
      check(hi > ep/2 - 0.01 && hi < ep/2 + 0.01, rq, "high phase", hi, ep/2);
      check(glitches == g0, "R4", "short phases in switch", real'(glitches - g0), 0.0);
      cur = nsel;
    end

    // stop / resume at /8
    @(negedge xtal); sel = 3'd3; #1; wait_idle("R5");
    min_ok = half_of(3); g0 = glitches;
    @(negedge xtal); stop = 1'b1; #1;
    check(busy == 1'b1, "R5", "busy on stop", real'(busy), 1.0);
    wait_idle("R6");
    e0 = edges;
    repeat (40) @(negedge xtal);
    check(edges == e0 && clk_o == 1'b0, "R6", "parked low, edges", real'(edges - e0), 0.0);
    @(negedge xtal); stop = 1'b0; #1; wait_idle("R6");
    measure(per, hi);
    check(per > 63.99 && per < 64.01, "R6", "resume period", per, 64.0);
    check(glitches == g0, "R4", "short phases stop/resume", real'(glitches - g0), 0.0);

    // synchronous card mode
    mon_en = 1'b0;
    @(negedge xtal); smode = 1'b1; sbit = 1'b1; #1;
    check(clk_o == 1'b1, "R7", "follows bit high", real'(clk_o), 1.0);
    @(negedge xtal); sel = 3'd4; stop = 1'b1; #1;
    check(clk_o == 1'b1, "R7", "select ignored", real'(clk_o), 1.0);
    @(negedge xtal); sbit = 1'b0; #1;
    check(clk_o == 1'b0, "R7", "follows bit low", real'(clk_o), 0.0);
    e0 = edges;
    repeat (30) @(negedge xtal);
    check(edges == e0, "R7", "no source edges", real'(edges - e0), 0.0);
    @(negedge xtal); smode = 1'b0; stop = 1'b0; sel = 3'd0; #1;
    wait_idle("R5");
    measure(per, hf);
    check(per > XP - 0.01 && per < XP + 0.01, "R1", "period after sync exit", per, XP);

    summary();
    $finish;
  end

  initial begin
    #(200000.0 * XP);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end
endmodule